// File: doc/BRIEF.md
# SD Host Data FIFO with Early-Warning Flow Control

This block is the word buffer between the host bus and the data path of an SD host controller. One store of 32 words of 32 bits is used in either direction, chosen by a direction input. When sending to the card, the host writes and the card side reads. When receiving from the card, the card side writes and the host reads. Strobes from the side that does not match the current direction are ignored. Status outputs report the fill level, full, empty, half-level and data-available conditions for the active direction. Two sticky error flags record a card-side write into a full receive buffer and a card-side read from an empty transmit buffer.

When flow control is switched on, the full and empty warnings move two words early. A clock-stop output is raised while the warning holds, so that the card clock can be paused before data is lost. In this mode the error flags are never set. A refused strobe is simply dropped.

A transfer-start pulse empties the buffer and loads a 24-bit count of words still to move. Each word accepted on the card side decrements that count, and it stops at zero.

Top module: `sdfifo_flow`

## Requirements
- R1: The buffer holds up to 32 words of 32 bits in first-in first-out order, and `level` reports how many are held. A write is accepted only when fewer than 32 words are held, and a read only when at least one is held. A read and a write may both be accepted in the same cycle. `host_rdata` shows the oldest word while `level` is non-zero.
- R2: With `dir_rx`=0 (transmit), only `host_wr` writes and only `card_rd` reads. With `dir_rx`=1 (receive), only `card_wr` writes and only `host_rd` reads. Any other strobe leaves `level` unchanged.
- R3: With flow control off, the active direction's full flag is high exactly when `level` is 32 and its empty flag exactly when `level` is 0. All flags of the inactive direction are low.
- R4: `rx_half_full` is high in receive mode when `level` is at least 8. `tx_half_empty` is high in transmit mode when 32 minus `level` is at least 8.
- R5: `rx_avail` (receive mode) and `tx_avail` (transmit mode) are high when `level` is non-zero.
- R6: With `flow_en`=1, `tx_empty` is high when `level` is 2 or less, and `rx_full` is high when `level` is 30 or more.
- R7: `clk_stop` is high exactly when `flow_en`=1 and the active direction's early condition of R6 holds.
- R8: With `flow_en`=0, `card_wr` in receive mode at `level` 32 drops the word and sets `rx_overrun`. `card_rd` in transmit mode at `level` 0 sets `tx_underrun`. Both flags stay set until cleared. `card_rdata` is the oldest word in transmit mode when `level` is non-zero, and 0 otherwise.
- R9: With `flow_en`=1, neither error flag is ever set, and refused strobes are dropped.
- R10: `err_clr` clears both error flags at the next edge. An error raised in the same cycle wins over the clear.
- R11: `xfer_start` empties the buffer (`level` 0 at the next edge) and loads `remain` from `xfer_words`. Strobes in that cycle are ignored, and the error flags are not changed by it.
- R12: `remain` decrements by one for each word accepted on the card side, and it holds at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_rx | input | 1 | 0 transmit (host to card), 1 receive (card to host) |
| flow_en | input | 1 | Early-warning flow control enable |
| xfer_start | input | 1 | Start of transfer: empty buffer, load count |
| xfer_words | input | 24 | Words to move in the new transfer |
| err_clr | input | 1 | Clear both error flags |
| host_wr | input | 1 | Host write strobe (transmit) |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe (receive) |
| host_rdata | output | 32 | Oldest word held |
| card_wr | input | 1 | Card-side write strobe (receive) |
| card_wdata | input | 32 | Card-side write data |
| card_rd | input | 1 | Card-side read strobe (transmit) |
| card_rdata | output | 32 | Word to the card, 0 when none |
| level | output | 6 | Words held |
| remain | output | 24 | Words still to move |
| tx_empty | output | 1 | Transmit empty (early with flow control) |
| tx_full | output | 1 | Transmit full |
| tx_half_empty | output | 1 | Transmit room for at least 8 words |
| tx_avail | output | 1 | Transmit data present |
| rx_empty | output | 1 | Receive empty |
| rx_full | output | 1 | Receive full (early with flow control) |
| rx_half_full | output | 1 | Receive holds at least 8 words |
| rx_avail | output | 1 | Receive data present |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_underrun | output | 1 | Sticky transmit underrun |
| clk_stop | output | 1 | Request to pause the card clock |

## Verification
`level`, `remain`, the error flags and every status flag come from registers. Each is due one rising edge after the strobe that moves it. The flags also follow `dir_rx` and `flow_en` through logic only, so a change on those two inputs shows up in the same cycle. `host_rdata` and `card_rdata` follow the stored head through logic only, and are due in the same cycle.

The bench drives inputs just after a falling edge and checks the read data 1 ns later. It updates its queue model for the coming edge, then compares every registered result at the next falling edge. Each comparison therefore sees exactly one edge's worth of change.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

   typedef enum logic {
      SDF_DIR_TX = 1'b0,
      SDF_DIR_RX = 1'b1
   } sdf_dir_e;

   typedef struct packed {
      logic tx_empty;
      logic tx_full;
      logic tx_half_empty;
      logic tx_avail;
      logic rx_empty;
      logic rx_full;
      logic rx_half_full;
      logic rx_avail;
   } sdf_flags_t;

endpackage

// File: rtl/sdf_store.sv
// Word store with wrap-around pointers and an occupancy counter.
// push/pop arrive already qualified by the parent.
module sdf_store #(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 32,
   parameter bit CLEAR_MEM = 1'b0,
   localparam int PTR_W    = $clog2(DEPTH),
   localparam int LVL_W    = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [LVL_W-1:0]  level
);

   if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("sdf_store: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [LVL_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (restart) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   if (CLEAR_MEM) begin : g_mem_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (push && !restart) begin
            mem[wr_ptr] <= wdata;
         end
      end
   end else begin : g_mem_plain
      always_ff @(posedge clk) begin
         if (push && !restart) mem[wr_ptr] <= wdata;
      end
   end

   assign head  = mem[rd_ptr];
   assign level = cnt;

endmodule

// File: rtl/sdf_flags.sv
// Status decode from the occupancy, with early thresholds under flow control.
module sdf_flags
   import sdf_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int WMARK  = 8,
   parameter int MARGIN = 2,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic [LVL_W-1:0] level,
   input  sdf_dir_e         dir,
   input  logic             flow_en,
   output sdf_flags_t       flags,
   output logic             clk_stop
);

   if (WMARK < 1 || WMARK > DEPTH) begin : g_bad_wmark
      $error("sdf_flags: WMARK out of range");
   end
   if (MARGIN < 0 || MARGIN >= DEPTH) begin : g_bad_margin
      $error("sdf_flags: MARGIN out of range");
   end

   localparam logic [LVL_W-1:0] LV_DEPTH = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] LV_WMARK = LVL_W'(WMARK);
   localparam logic [LVL_W-1:0] LV_ELOW  = LVL_W'(MARGIN);
   localparam logic [LVL_W-1:0] LV_EHIGH = LVL_W'(DEPTH - MARGIN);

   logic [LVL_W-1:0] room;
   logic             is_rx, at_full, at_empty, near_full, near_empty;

   always_comb begin
      room       = LV_DEPTH - level;
      is_rx      = (dir == SDF_DIR_RX);
      at_full    = (level == LV_DEPTH);
      at_empty   = (level == '0);
      near_full  = (level >= LV_EHIGH);
      near_empty = (level <= LV_ELOW);
      flags      = '0;
      if (is_rx) begin
         flags.rx_empty     = at_empty;
         flags.rx_full      = flow_en ? near_full : at_full;
         flags.rx_half_full = (level >= LV_WMARK);
         flags.rx_avail     = !at_empty;
      end else begin
         flags.tx_empty      = flow_en ? near_empty : at_empty;
         flags.tx_full       = at_full;
         flags.tx_half_empty = (room >= LV_WMARK);
         flags.tx_avail      = !at_empty;
      end
      clk_stop = flow_en && (is_rx ? near_full : near_empty);
   end

endmodule

// File: rtl/sdf_track.sv
// Remaining-word counter and the two sticky error flags.
module sdf_track #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] load_val,
   input  logic             move,
   input  logic             ovr_set,
   input  logic             und_set,
   input  logic             err_clr,
   output logic [CNT_W-1:0] remain,
   output logic             ovr_flag,
   output logic             und_flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (restart) begin
         remain <= load_val;
      end else if (move && remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_flag <= 1'b0;
         und_flag <= 1'b0;
      end else begin
         if (ovr_set)      ovr_flag <= 1'b1;
         else if (err_clr) ovr_flag <= 1'b0;
         if (und_set)      und_flag <= 1'b1;
         else if (err_clr) und_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/sdfifo_flow.sv
module sdfifo_flow
   import sdf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 32,
   parameter int WMARK     = 8,
   parameter int MARGIN    = 2,
   parameter int CNT_W     = 24,
   parameter bit CLEAR_MEM = 1'b0,
   localparam int LVL_W    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_rx,
   input  logic              flow_en,
   input  logic              xfer_start,
   input  logic [CNT_W-1:0]  xfer_words,
   input  logic              err_clr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              card_wr,
   input  logic [DATA_W-1:0] card_wdata,
   input  logic              card_rd,
   output logic [DATA_W-1:0] card_rdata,
   output logic [LVL_W-1:0]  level,
   output logic [CNT_W-1:0]  remain,
   output logic              tx_empty,
   output logic              tx_full,
   output logic              tx_half_empty,
   output logic              tx_avail,
   output logic              rx_empty,
   output logic              rx_full,
   output logic              rx_half_full,
   output logic              rx_avail,
   output logic              rx_overrun,
   output logic              tx_underrun,
   output logic              clk_stop
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("sdfifo_flow: CNT_W must be positive");
   end

   localparam logic [LVL_W-1:0] LV_DEPTH = LVL_W'(DEPTH);

   sdf_dir_e          dir;
   sdf_flags_t        flg;
   logic              src_wr, src_rd, push, pop, move;
   logic              ovr_set, und_set, is_full, is_empty;
   logic [DATA_W-1:0] src_data, head;

   assign dir      = dir_rx ? SDF_DIR_RX : SDF_DIR_TX;
   assign is_full  = (level == LV_DEPTH);
   assign is_empty = (level == '0);

   always_comb begin
      if (dir == SDF_DIR_RX) begin
         src_wr   = card_wr;
         src_rd   = host_rd;
         src_data = card_wdata;
      end else begin
         src_wr   = host_wr;
         src_rd   = card_rd;
         src_data = host_wdata;
      end
      push    = !xfer_start && src_wr && !is_full;
      pop     = !xfer_start && src_rd && !is_empty;
      move    = (dir == SDF_DIR_RX) ? push : pop;
      ovr_set = !xfer_start && !flow_en && (dir == SDF_DIR_RX) && card_wr && is_full;
      und_set = !xfer_start && !flow_en && (dir == SDF_DIR_TX) && card_rd && is_empty;
   end

   sdf_store #(
      .DATA_W    (DATA_W),
      .DEPTH     (DEPTH),
      .CLEAR_MEM (CLEAR_MEM)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (xfer_start),
      .push    (push),
      .pop     (pop),
      .wdata   (src_data),
      .head    (head),
      .level   (level)
   );

   sdf_flags #(
      .DEPTH  (DEPTH),
      .WMARK  (WMARK),
      .MARGIN (MARGIN)
   ) u_flags (
      .level    (level),
      .dir      (dir),
      .flow_en  (flow_en),
      .flags    (flg),
      .clk_stop (clk_stop)
   );

   sdf_track #(
      .CNT_W (CNT_W)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (xfer_start),
      .load_val (xfer_words),
      .move     (move),
      .ovr_set  (ovr_set),
      .und_set  (und_set),
      .err_clr  (err_clr),
      .remain   (remain),
      .ovr_flag (rx_overrun),
      .und_flag (tx_underrun)
   );

   assign host_rdata    = head;
   assign card_rdata    = (dir == SDF_DIR_TX && !is_empty) ? head : '0;
   assign tx_empty      = flg.tx_empty;
   assign tx_full       = flg.tx_full;
   assign tx_half_empty = flg.tx_half_empty;
   assign tx_avail      = flg.tx_avail;
   assign rx_empty      = flg.rx_empty;
   assign rx_full       = flg.rx_full;
   assign rx_half_full  = flg.rx_half_full;
   assign rx_avail      = flg.rx_avail;

endmodule

// File: rtl/sdfifo_flow_chk.sv
module sdfifo_flow_chk #(
   parameter int DEPTH  = 32,
   parameter int CNT_W  = 24,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dir_rx,
   input logic             flow_en,
   input logic             xfer_start,
   input logic [CNT_W-1:0] xfer_words,
   input logic             err_clr,
   input logic [LVL_W-1:0] level,
   input logic [CNT_W-1:0] remain,
   input logic             tx_empty,
   input logic             tx_full,
   input logic             tx_avail,
   input logic             rx_avail,
   input logic             rx_overrun,
   input logic             tx_underrun,
   input logic             clk_stop
);

   p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   p_level_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_start |=> (level == $past(level) || level == $past(level) + 1'b1
                       || level + 1'b1 == $past(level)));

   p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_avail && rx_avail));

   p_tx_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_full, tx_empty}));

   p_stop_needs_flow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop |-> flow_en);

   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun && !err_clr) |=> rx_overrun);

   p_und_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_underrun && !err_clr) |=> tx_underrun);

   p_flow_no_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && !rx_overrun) |=> !rx_overrun);

   p_flow_no_und_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && !tx_underrun) |=> !tx_underrun);

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && flow_en) |=> (!rx_overrun && !tx_underrun));

   p_start_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> (level == '0 && remain == $past(xfer_words)));

   p_remain_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_start |=> (remain == $past(remain) || remain + 1'b1 == $past(remain)));

   wire unused_dir = dir_rx;

endmodule

bind sdfifo_flow sdfifo_flow_chk #(
   .DEPTH (DEPTH),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dir_rx      (dir_rx),
   .flow_en     (flow_en),
   .xfer_start  (xfer_start),
   .xfer_words  (xfer_words),
   .err_clr     (err_clr),
   .level       (level),
   .remain      (remain),
   .tx_empty    (tx_empty),
   .tx_full     (tx_full),
   .tx_avail    (tx_avail),
   .rx_avail    (rx_avail),
   .rx_overrun  (rx_overrun),
   .tx_underrun (tx_underrun),
   .clk_stop    (clk_stop)
);

// File: tb/test_sdfifo_flow.sv
`timescale 1ns/1ps
module test_sdfifo_flow;

   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dir_rx = 1'b0, flow_en = 1'b0, xfer_start = 1'b0, err_clr = 1'b0;
   logic [23:0] xfer_words = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0, card_wr = 1'b0, card_rd = 1'b0;
   logic [31:0] host_wdata = '0, card_wdata = '0;
   logic [31:0] host_rdata, card_rdata;
   logic [5:0]  level;
   logic [23:0] remain;
   logic        tx_empty, tx_full, tx_half_empty, tx_avail;
   logic        rx_empty, rx_full, rx_half_full, rx_avail;
   logic        rx_overrun, tx_underrun, clk_stop;

   always #4 clk = ~clk;

   sdfifo_flow i_sdfifo_flow (
      .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .flow_en(flow_en),
      .xfer_start(xfer_start), .xfer_words(xfer_words), .err_clr(err_clr),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
      .host_rdata(host_rdata), .card_wr(card_wr), .card_wdata(card_wdata),
      .card_rd(card_rd), .card_rdata(card_rdata), .level(level), .remain(remain),
      .tx_empty(tx_empty), .tx_full(tx_full), .tx_half_empty(tx_half_empty),
      .tx_avail(tx_avail), .rx_empty(rx_empty), .rx_full(rx_full),
      .rx_half_full(rx_half_full), .rx_avail(rx_avail), .rx_overrun(rx_overrun),
      .tx_underrun(tx_underrun), .clk_stop(clk_stop)
   );

   int          checks = 0, errors = 0;
   logic [31:0] q[$];
   bit          m_ovr = 0, m_und = 0;
   int          m_rem = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_flags();
      int n = q.size();
      logic [7:0] f = '0;
      if (dir_rx) begin
         f[3] = (n == 0);
         f[2] = flow_en ? (n >= DEPTH - 2) : (n == DEPTH);
         f[1] = (n >= 8);
         f[0] = (n != 0);
      end else begin
         f[7] = flow_en ? (n <= 2) : (n == 0);
         f[6] = (n == DEPTH);
         f[5] = (DEPTH - n >= 8);
         f[4] = (n != 0);
      end
      return f;
   endfunction

   task automatic check_regs();
      logic [7:0] ef = exp_flags();
      logic [7:0] af = {tx_empty, tx_full, tx_half_empty, tx_avail,
                        rx_empty, rx_full, rx_half_full, rx_avail};
      logic       es = flow_en && (dir_rx ? (q.size() >= DEPTH - 2) : (q.size() <= 2));
      chk("R1", "level", 32'(level), 32'(q.size()));
      chk(flow_en ? "R6" : "R3", "full/empty", {28'd0, af[7:6], af[3:2]},
          {28'd0, ef[7:6], ef[3:2]});
      chk("R4", "half", {30'd0, af[5], af[1]}, {30'd0, ef[5], ef[1]});
      chk("R5", "avail", {30'd0, af[4], af[0]}, {30'd0, ef[4], ef[0]});
      chk("R7", "clk_stop", 32'(clk_stop), 32'(es));
      chk("R8", "errors", {30'd0, rx_overrun, tx_underrun}, {30'd0, m_ovr, m_und});
      chk("R12", "remain", 32'(remain), 32'(m_rem));
   endtask

   // One clock: check read data, update the model for the coming edge,
   // then compare registered results at the following falling edge.
   task automatic tick();
      int  n;
      bit  w, r, aw, ar, os, us;
      logic [31:0] wd;
      #1;
      n = q.size();
      if (n > 0) chk("R1", "host_rdata", host_rdata, q[0]);
      chk((!dir_rx && n > 0) ? "R1" : "R8", "card_rdata", card_rdata,
          (!dir_rx && n > 0) ? q[0] : 32'd0);
      os = 0; us = 0;
      if (xfer_start) begin
         q.delete();
         m_rem = int'(xfer_words);
      end else begin
         w  = dir_rx ? card_wr : host_wr;
         r  = dir_rx ? host_rd : card_rd;
         wd = dir_rx ? card_wdata : host_wdata;
         aw = w && n < DEPTH;
         ar = r && n > 0;
         os = dir_rx && card_wr && n == DEPTH && !flow_en;
         us = !dir_rx && card_rd && n == 0 && !flow_en;
         if (ar) void'(q.pop_front());
         if (aw) q.push_back(wd);
         if ((dir_rx ? aw : ar) && m_rem > 0) m_rem--;
      end
      if (err_clr) begin m_ovr = 0; m_und = 0; end
      if (os) m_ovr = 1;
      if (us) m_und = 1;
      @(posedge clk);
      @(negedge clk);
      check_regs();
   endtask

   task automatic cyc(bit hw, bit hr, bit cw, bit cr, bit st = 0, bit clr = 0);
      host_wr = hw; host_rd = hr; card_wr = cw; card_rd = cr;
      xfer_start = st; err_clr = clr;
      host_wdata = $urandom; card_wdata = $urandom;
      tick();
      host_wr = 0; host_rd = 0; card_wr = 0; card_rd = 0;
      xfer_start = 0; err_clr = 0;
   endtask

   task automatic begin_xfer(bit rx, bit fl, int words);
      dir_rx = rx; flow_en = fl; xfer_words = 24'(words);
      cyc(0, 0, 0, 0, 1, 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_regs();   // reset state

      // Transmit, no flow control: fill, overfill, drain, underrun
      begin_xfer(0, 0, 40);
      chk("R11", "remain load", 32'(remain), 32'd40);
      for (int i = 0; i < 33; i++) cyc(1, 0, 0, 0);
      chk("R1", "full level", 32'(level), 32'd32);
      cyc(0, 1, 1, 0);
      chk("R2", "wrong side ignored", 32'(level), 32'd32);
      cyc(1, 0, 0, 1);
      chk("R1", "write refused at full, read ok", 32'(level), 32'd31);
      for (int i = 0; i < 32; i++) cyc(0, 0, 0, 1);
      chk("R8", "underrun", 32'(tx_underrun), 32'd1);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R10", "clear", 32'(tx_underrun), 32'd0);

      // Receive, no flow control: overrun, clear collision
      begin_xfer(1, 0, 100);
      for (int i = 0; i < 33; i++) cyc(0, 0, 1, 0);
      chk("R8", "overrun", 32'(rx_overrun), 32'd1);
      cyc(0, 0, 1, 0, 0, 1);
      chk("R10", "set wins over clear", 32'(rx_overrun), 32'd1);
      begin_xfer(1, 0, 100);
      chk("R11", "start keeps error", 32'(rx_overrun), 32'd1);
      cyc(0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0);
      for (int i = 0; i < 12; i++) cyc(0, 1, 1, 0);
      chk("R1", "simultaneous", 32'(level), 32'd10);
      cyc(0, 0, 1, 0, 1, 0);
      chk("R11", "start ignores strobe", 32'(level), 32'd0);

      // Receive with flow control: early full, no overrun
      begin_xfer(1, 1, 200);
      for (int i = 0; i < 30; i++) cyc(0, 0, 1, 0);
      chk("R6", "early rx_full", 32'(rx_full), 32'd1);
      chk("R7", "clk_stop rx", 32'(clk_stop), 32'd1);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
      chk("R9", "no overrun", 32'(rx_overrun), 32'd0);

      // Transmit with flow control: early empty, no underrun
      begin_xfer(0, 1, 5);
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      chk("R6", "tx_empty off at 3", 32'(tx_empty), 32'd0);
      cyc(0, 0, 0, 1);
      chk("R6", "tx_empty at 2", 32'(tx_empty), 32'd1);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
      chk("R9", "no underrun", 32'(tx_underrun), 32'd0);

      // Remaining count saturates
      begin_xfer(1, 0, 3);
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
      chk("R12", "remain at zero", 32'(remain), 32'd0);

      // Random mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 99) == 0) flow_en = ~flow_en;
         if ($urandom_range(0, 149) == 0) dir_rx = ~dir_rx;
         xfer_words = 24'($urandom_range(0, 60));
         cyc($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
             $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
             $urandom_range(0, 79) == 0, $urandom_range(0, 39) == 0);
      end

      finish_run();
   end

endmodule